// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block sits on a two-wire serial bus as a slave and lets an external controller read and write a bank of 8-bit configuration registers inside the chip. It answers one fixed 7-bit device address. Every transaction moves exactly one register. A write carries the device address, a register index and one data byte. A read first loads the index with a short write phase, then uses a repeated START and a read phase, and the slave shifts the selected register back out.

Both bus lines pass through a two-flop synchroniser and a glitch filter that runs on the system clock. Edges are then detected on the cleaned levels. SDA is open-drain: the block never drives it high and only asserts an output enable that pulls the line low. Logic elsewhere in the chip sees the live register contents through a combinational read port.

Top module: `i2cs_regif`

## Requirements
- R1: A byte after START whose upper seven bits equal 7'b0111110 (0x3E) is acknowledged: the slave pulls SDA low for the ninth clock. Bit 0 of that byte selects direction, 0 for write and 1 for read.
- R2: After any other address the slave gives no acknowledge and leaves SDA released. It ignores all later bytes until the next START or STOP, so the registers do not change.
- R3: A write of address+0, index, data acknowledges all three bytes and stores the data byte in the register at that index.
- R4: A register is written only after all 8 data bits have been received. A STOP partway through the data byte leaves the register unchanged.
- R5: A read of address+0, index, repeated START, address+1 acknowledges the three incoming bytes. It then returns the indexed register MSB first. The value is latched when the data byte begins.
- R6: During the ninth clock of the read data byte the slave releases SDA. After STOP it is idle and serves the next transaction normally.
- R7: After reset, SDA is released and register i holds i XOR 8'hA5.
- R8: The slave changes its SDA output enable only while SCL is low.
- R9: The stored index never auto-increments and survives between transactions. A read phase that follows START directly, with no index phase, returns the register at the last stored index, and does so again on repeat.
- R10: A START in the middle of a byte restarts address reception, and the transaction that follows works normally.
- R11: A pulse on SCL or SDA shorter than FILT system clocks is filtered out and does not count as a bus edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_idx | input | 8 | Index for the on-chip read port |
| cfg_data | output | 8 | Contents of register cfg_idx |

## Verification
A wrong sequencer state shows up as an acknowledge bit of the wrong value in the same ninth clock. It can also show up as read data that is shifted by one bit, or inverted at the first differing bit of the byte. A write that commits too early, or to the wrong index, appears on the on-chip read port about two system clocks after the eighth data edge. A corrupted stored index is first seen in the next read phase as data from another register. Output-enable activity while SCL is high is seen at once by a monitor that watches the output enable against SCL.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int IDX_W = 8;
    localparam int DAT_W = 8;
    localparam int NREG  = 1 << IDX_W;
    localparam int BCW   = $clog2(DAT_W);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [DAT_W-1:0] dat_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_IDX, S_WDAT, S_ACK, S_RDAT, S_IGNORE
    } st_t;

    function automatic dat_t reg_rst_val(input int i);
        return dat_t'(i) ^ dat_t'(8'hA5);
    endfunction
endpackage

// File: rtl/i2cs_filt.sv
module i2cs_filt #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic q
);
    localparam int CW = $clog2(FILT + 1);
    logic s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            q   <= 1'b1;
            cnt <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 != q) begin
                if (cnt == CW'(FILT - 1)) begin
                    q   <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    assert_filter_follows_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> ($past(s2) == q));
endmodule

// File: rtl/i2cs_bank.sv
module i2cs_bank
    import i2cs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  idx_t widx,
    input  dat_t wdata,
    input  idx_t ridx_a,
    output dat_t rdata_a,
    input  idx_t ridx_b,
    output dat_t rdata_b
);
    dat_t mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= reg_rst_val(i);
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

    assert_commit_lands_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3E
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_lvl,
    input  logic sda_lvl,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start,
    input  logic stop,
    input  dat_t rdata,
    output idx_t idx,
    output logic we,
    output dat_t wdata,
    output logic sda_oe
);
    st_t st, after;
    logic [BCW-1:0] bitcnt;
    dat_t sh;
    dat_t nxt_byte;

    assign nxt_byte = {sh[DAT_W-2:0], sda_lvl};
    assign wdata    = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            after  <= S_IDLE;
            bitcnt <= '0;
            sh     <= '0;
            sda_oe <= 1'b0;
            idx    <= '0;
            we     <= 1'b0;
        end else begin
            we <= 1'b0;
            if (start) begin
                st     <= S_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_IDX, S_WDAT: if (scl_rise) begin
                        sh     <= nxt_byte;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == BCW'(DAT_W - 1)) begin
                            case (st)
                                S_ADDR: begin
                                    if (nxt_byte[7:1] == DEV_ADDR) begin
                                        st    <= S_ACK;
                                        after <= nxt_byte[0] ? S_RDAT : S_IDX;
                                    end else begin
                                        st <= S_IGNORE;
                                    end
                                end
                                S_IDX: begin
                                    idx   <= idx_t'(nxt_byte);
                                    st    <= S_ACK;
                                    after <= S_WDAT;
                                end
                                default: begin
                                    we    <= 1'b1;
                                    st    <= S_ACK;
                                    after <= S_IGNORE;
                                end
                            endcase
                        end
                    end
                    S_ACK: if (scl_fall) begin
                        if (!sda_oe) begin
                            sda_oe <= 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= after;
                            bitcnt <= '0;
                            if (after == S_RDAT) begin
                                sh     <= rdata;
                                sda_oe <= ~rdata[DAT_W-1];
                            end
                        end
                    end
                    S_RDAT: if (scl_fall) begin
                        if (bitcnt == BCW'(DAT_W - 1)) begin
                            sda_oe <= 1'b0;
                            st     <= S_IGNORE;
                        end else begin
                            sh     <= {sh[DAT_W-2:0], 1'b0};
                            sda_oe <= ~sh[DAT_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (st == S_IGNORE) |-> !sda_oe);
    assert_start_restart_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> (st == S_ADDR && bitcnt == '0));
    assert_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_RDAT && !scl_fall && !start && !stop) |=> $stable(sh));
    assert_stop_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> (st == S_IDLE && !sda_oe));
endmodule

// File: rtl/i2cs_regif.sv
module i2cs_regif
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3E,
    parameter int         FILT     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] cfg_idx,
    output logic [7:0] cfg_data
);
    logic scl_f, sda_f, scl_d, sda_d;
    logic scl_rise, scl_fall, start, stop;
    logic we;
    idx_t idx;
    dat_t wdata, rdata;

    i2cs_filt #(.FILT(FILT)) u_fscl (.clk(clk), .rst(rst), .raw(scl_i), .q(scl_f));
    i2cs_filt #(.FILT(FILT)) u_fsda (.clk(clk), .rst(rst), .raw(sda_i), .q(sda_f));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
    assign start    = scl_f & scl_d & sda_d & ~sda_f;
    assign stop     = scl_f & scl_d & ~sda_d & sda_f;

    i2cs_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .scl_lvl(scl_f), .sda_lvl(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop),
        .rdata(rdata), .idx(idx), .we(we), .wdata(wdata), .sda_oe(sda_oe)
    );

    i2cs_bank u_bank (
        .clk(clk), .rst(rst), .we(we), .widx(idx), .wdata(wdata),
        .ridx_a(idx), .rdata_a(rdata),
        .ridx_b(idx_t'(cfg_idx)), .rdata_b(cfg_data)
    );
endmodule

// File: tb/sim_i2cs_regif.sv
module sim_i2cs_regif;
    localparam int Q = 10;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [7:0] cfg_idx = 8'h00;
    logic [7:0] cfg_data;
    int n_chk = 0, n_bad = 0, viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] model [256];

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cs_regif u0 (.clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
                   .sda_oe(sda_oe), .cfg_idx(cfg_idx), .cfg_data(cfg_data));

    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_m) viol++;
        prev_oe = sda_oe;
    end

    function automatic logic [7:0] exp_rst(input int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        if (!scl_m) begin sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait(); end
        sda_m = 1'b0; q_wait(); scl_m = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q_wait(); scl_m = 1'b1; q_wait(); sda_m = 1'b1; q_wait();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; q_wait(); scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait(); b = sda_line; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(ack);
    endtask

    task automatic recv(output logic [7:0] v, output logic rel);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        rbit(rel);
    endtask

    task automatic do_write(input logic [7:0] ix, input logic [7:0] d, output logic [2:0] a);
        bus_start(); send(8'h7C, a[2]); send(ix, a[1]); send(d, a[0]); bus_stop();
    endtask

    task automatic do_read(input logic [7:0] ix, output logic [7:0] d,
                           output logic [2:0] a, output logic rel);
        bus_start(); send(8'h7C, a[2]); send(ix, a[1]);
        bus_start(); send(8'h7D, a[0]); recv(d, rel); bus_stop();
    endtask

    task automatic cfg_peek(input logic [7:0] ix, output logic [7:0] d);
        cfg_idx = ix; @(negedge clk); d = cfg_data;
    endtask

    initial begin
        logic [2:0] a;
        logic [7:0] d;
        logic rel, ak;
        int seed = 7;
        void'($urandom(seed));
        for (int i = 0; i < 256; i++) model[i] = exp_rst(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R7 reset state
        check("R7 oe", sda_oe, 0);
        cfg_peek(8'h00, d); check("R7 reg00", d, exp_rst(0));
        cfg_peek(8'h5A, d); check("R7 reg5A", d, exp_rst(8'h5A));

        // R1 R3 basic write
        do_write(8'h12, 8'h3C, a); model[8'h12] = 8'h3C;
        check("R1 addr ack", a[2], 0);
        check("R3 acks", a, 3'b000);
        cfg_peek(8'h12, d); check("R3 data", d, 8'h3C);

        // R5 R6 random read
        do_read(8'h12, d, a, rel);
        check("R5 acks", a, 3'b000);
        check("R5 data", d, 8'h3C);
        check("R6 release", rel, 1);
        do_read(8'h80, d, a, rel);
        check("R5 reset reg read", d, exp_rst(8'h80));
        check("R6 next tx", a, 3'b000);

        // R2 wrong address
        bus_start(); send(8'h7E, ak); check("R2 no ack", ak, 1);
        send(8'h12, ak); check("R2 idx ignored", ak, 1);
        send(8'hFF, ak); check("R2 data ignored", ak, 1);
        bus_stop();
        cfg_peek(8'h12, d); check("R2 reg kept", d, 8'h3C);

        // R4 stop partway through data byte
        bus_start(); send(8'h7C, ak); send(8'h12, ak);
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        bus_stop();
        cfg_peek(8'h12, d); check("R4 no partial commit", d, 8'h3C);

        // R9 index persists, no auto-increment
        do_read(8'h33, d, a, rel);
        bus_start(); send(8'h7D, ak); recv(d, rel); bus_stop();
        check("R9 ack", ak, 0);
        check("R9 same reg", d, model[8'h33]);
        bus_start(); send(8'h7D, ak); recv(d, rel); bus_stop();
        check("R9 again no incr", d, model[8'h33]);

        // R10 START mid-byte
        bus_start(); send(8'h7C, ak); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        do_write(8'h44, 8'hC3, a); model[8'h44] = 8'hC3;
        check("R10 acks", a, 3'b000);
        cfg_peek(8'h44, d); check("R10 data", d, 8'hC3);

        // R11 one-cycle SCL glitch while SCL low
        bus_start();
        for (int i = 7; i >= 0; i--) begin
            sda_m = i inside {6, 5, 4, 3, 2} ? 1'b1 : 1'b0;
            repeat (Q / 2) @(negedge clk);
            if (i == 4) begin scl_m = 1'b1; @(negedge clk); scl_m = 1'b0; end
            repeat (Q - Q / 2) @(negedge clk);
            scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
        end
        rbit(ak); check("R11 glitch ignored ack", ak, 0);
        send(8'h55, ak); send(8'h96, ak); bus_stop(); model[8'h55] = 8'h96;
        cfg_peek(8'h55, d); check("R11 write ok", d, 8'h96);

        // random write/read pairs R3 R5
        for (int k = 0; k < 24; k++) begin
            logic [7:0] ix, dv;
            ix = 8'($urandom); dv = 8'($urandom);
            if (k % 3 != 0) begin
                do_write(ix, dv, a); model[ix] = dv;
                check("R3 rand acks", a, 3'b000);
            end
            do_read(ix, d, a, rel);
            check("R5 rand data", d, model[ix]);
            check("R6 rand release", rel, 1);
        end

        check("R8 oe changes only with SCL low", viol, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule